// File: doc/BRIEF.md
# Grouped Read/Write Segment Access Scheduler

This block shares one wide, single-port segment memory between two request streams. Incoming segments arrive as write requests carrying an address and a full 576-bit segment. Outgoing traffic arrives as read requests carrying an address and a tag. Every access moves one whole segment to or from an unrelated address. The scheduler issues accesses in groups that all go the same way, so the idle cycles needed to turn the memory data bus around are spent once per group, not once per access.

Under full load the command stream settles into four writes, a turnaround gap, four reads, another gap, and so on. Half of all accesses are then writes, and the sustained segment input rate is four segments every `8 + 2*TURN_CYC` cycles. When a group's own queue runs dry and the other queue is waiting, the group is cut short and the direction flips. When the other queue is empty, the scheduler stays on its direction without any gap. The memory returns read data a fixed number of cycles after each read command. The block attaches the matching tag and forwards the data. Address allocation and the storage array sit outside the block.

Top module: `seg_access_sched`

## Requirements
- R1: After a synchronous reset, no command is presented, no return is flagged, both request inputs are ready, and the current direction is write. A lone write offered after reset therefore reaches the memory port two cycles later, with no turnaround gap.
- R2: Each request input has a 4-entry queue, and its ready output is low exactly when that queue holds 4 entries. Every accepted request is issued exactly once.
- R3: While both queues hold requests, each group issues exactly GROUP (4) accesses of one direction before the direction changes. At most one command is issued per cycle.
- R4: Each direction change leaves exactly TURN_CYC (default 2) cycles without a command between the last access of one direction and the first access of the other. Accesses in the same direction issue in back-to-back cycles.
- R5: If the current direction's queue empties before the group is complete while the other queue has requests, the direction changes early, and the TURN_CYC idle cycles are still inserted.
- R6: If the other queue is empty, the scheduler keeps its direction. This applies whether the current queue also empties or a full group has been reached while the current queue still has requests. In the second case the next group starts with no idle cycle.
- R7: Each queue is served in arrival order. The command carries the request's address, and for writes its full segment data, unchanged. `mem_we` is 1 for a write and 0 for a read. A request accepted in cycle c reaches the port no earlier than cycle c+2.
- R8: A read command presented in cycle c produces `ret_valid` in cycle c+RD_LAT (default 3), with that request's tag and `ret_data` equal to `mem_rdata` in that cycle. Returns come back in issue order.
- R9: With both inputs continuously offering requests and TURN_CYC=2, every 120-cycle window holds exactly 40 write commands and 40 read commands.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_valid | input | 1 | Write request offered |
| wr_ready | output | 1 | Write queue can accept |
| wr_addr | input | ADDR_W (16) | Segment address to write |
| wr_data | input | DATA_W (576) | Segment contents |
| rd_valid | input | 1 | Read request offered |
| rd_ready | output | 1 | Read queue can accept |
| rd_addr | input | ADDR_W (16) | Segment address to read |
| rd_tag | input | TAG_W (6) | Tag returned with the data |
| mem_en | output | 1 | Command valid this cycle |
| mem_we | output | 1 | 1 = write, 0 = read |
| mem_addr | output | ADDR_W (16) | Command address |
| mem_wdata | output | DATA_W (576) | Write segment data |
| mem_rdata | input | DATA_W (576) | Memory read data, RD_LAT cycles after a read command |
| ret_valid | output | 1 | Read return valid |
| ret_tag | output | TAG_W (6) | Tag of the returned segment |
| ret_data | output | DATA_W (576) | Returned segment |

## Verification
The hardest cases to reach are an early direction change and a held direction. Each needs one queue to be empty at exactly the moment the other is not, and a random mix rarely produces that state in a form that can be told apart. The bench therefore drains both queues and then injects a single request of chosen direction. It measures the cycle in which the command appears, and so distinguishes a held direction (two cycles) from a forced turnaround (two plus TURN_CYC). Long single-direction phases push the group counter past four with the other queue empty. A saturated phase fills both queues and fixes the repeating grouped pattern.

// File: rtl/seg_sched_pkg.sv
package seg_sched_pkg;

    typedef enum logic {
        DIR_WR = 1'b0,
        DIR_RD = 1'b1
    } seg_dir_e;

    typedef struct packed {
        logic     issue;
        seg_dir_e dir;
    } sched_act_t;

    function automatic seg_dir_e flip_dir(input seg_dir_e d);
        return (d == DIR_WR) ? DIR_RD : DIR_WR;
    endfunction

endpackage

// File: rtl/seg_req_fifo.sv
module seg_req_fifo #(
    parameter int WIDTH = 8,
    parameter int DEPTH = 4
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             in_valid,
    output logic             in_ready,
    input  logic [WIDTH-1:0] in_data,
    output logic             out_avail,
    output logic [WIDTH-1:0] out_data,
    input  logic             out_pop
);
    localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int CNT_W = $clog2(DEPTH + 1);
    localparam logic [PTR_W-1:0] LAST_SLOT = PTR_W'(DEPTH - 1);
    localparam logic [CNT_W-1:0] FULL_CNT  = CNT_W'(DEPTH);

    logic [WIDTH-1:0] slot_q [DEPTH];
    logic [PTR_W-1:0] head_q, tail_q;
    logic [CNT_W-1:0] fill_q;
    logic             push, pop;

    function automatic logic [PTR_W-1:0] bump(input logic [PTR_W-1:0] p);
        return (p == LAST_SLOT) ? '0 : p + PTR_W'(1);
    endfunction

    assign in_ready  = (fill_q != FULL_CNT);
    assign out_avail = (fill_q != '0);
    assign out_data  = slot_q[head_q];
    assign push      = in_valid && in_ready;
    assign pop       = out_pop && out_avail;

    always_ff @(posedge clk) begin
        if (push) slot_q[tail_q] <= in_data;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            head_q <= '0;
            tail_q <= '0;
            fill_q <= '0;
        end else begin
            if (push) tail_q <= bump(tail_q);
            if (pop)  head_q <= bump(head_q);
            case ({push, pop})
                2'b10:   fill_q <= fill_q + CNT_W'(1);
                2'b01:   fill_q <= fill_q - CNT_W'(1);
                default: fill_q <= fill_q;
            endcase
        end
    end
endmodule

// File: rtl/seg_dir_ctrl.sv
module seg_dir_ctrl
    import seg_sched_pkg::*;
#(
    parameter int GROUP    = 4,
    parameter int TURN_CYC = 2
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       wr_avail,
    input  logic       rd_avail,
    output sched_act_t act
);
    localparam int CNT_W = $clog2(GROUP + 1);
    localparam int TRN_W = (TURN_CYC > 0) ? $clog2(TURN_CYC + 1) : 1;
    localparam logic [CNT_W-1:0] GROUP_FULL  = CNT_W'(GROUP);
    localparam logic [CNT_W-1:0] CNT_ONE     = CNT_W'(1);
    localparam logic [TRN_W-1:0] TURN_RELOAD = (TURN_CYC > 0) ? TRN_W'(TURN_CYC - 1) : '0;

    seg_dir_e         dir_q, dir_d;
    logic [CNT_W-1:0] run_q, run_d;
    logic [TRN_W-1:0] gap_q, gap_d;
    logic             cur_avail, oth_avail;

    assign cur_avail = (dir_q == DIR_WR) ? wr_avail : rd_avail;
    assign oth_avail = (dir_q == DIR_WR) ? rd_avail : wr_avail;

    always_comb begin
        dir_d     = dir_q;
        run_d     = run_q;
        gap_d     = gap_q;
        act.issue = 1'b0;
        act.dir   = dir_q;
        if (gap_q != '0) begin
            gap_d = gap_q - TRN_W'(1);
        end else if (cur_avail && (run_q != GROUP_FULL)) begin
            act.issue = 1'b1;
            run_d     = run_q + CNT_ONE;
        end else if (oth_avail) begin
            dir_d = flip_dir(dir_q);
            if (TURN_CYC == 0) begin
                act.issue = 1'b1;
                act.dir   = dir_d;
                run_d     = CNT_ONE;
            end else begin
                run_d = '0;
                gap_d = TURN_RELOAD;
            end
        end else if (cur_avail) begin
            act.issue = 1'b1;
            run_d     = CNT_ONE;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            dir_q <= DIR_WR;
            run_q <= '0;
            gap_q <= '0;
        end else begin
            dir_q <= dir_d;
            run_q <= run_d;
            gap_q <= gap_d;
        end
    end
endmodule

// File: rtl/seg_ret_pipe.sv
module seg_ret_pipe #(
    parameter int TAG_W = 6,
    parameter int LAT   = 3
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             cmd_rd,
    input  logic [TAG_W-1:0] cmd_tag,
    output logic             ret_valid,
    output logic [TAG_W-1:0] ret_tag
);
    logic [LAT-1:0]   stg_vld_q;
    logic [TAG_W-1:0] stg_tag_q [LAT];

    always_ff @(posedge clk) begin
        if (rst) stg_vld_q[0] <= 1'b0;
        else     stg_vld_q[0] <= cmd_rd;
        stg_tag_q[0] <= cmd_tag;
    end

    for (genvar s = 1; s < LAT; s++) begin : g_stage
        always_ff @(posedge clk) begin
            if (rst) stg_vld_q[s] <= 1'b0;
            else     stg_vld_q[s] <= stg_vld_q[s-1];
            stg_tag_q[s] <= stg_tag_q[s-1];
        end
    end

    assign ret_valid = stg_vld_q[LAT-1];
    assign ret_tag   = stg_tag_q[LAT-1];
endmodule

// File: rtl/seg_access_sched.sv
module seg_access_sched
    import seg_sched_pkg::*;
#(
    parameter int ADDR_W   = 16,
    parameter int DATA_W   = 576,
    parameter int TAG_W    = 6,
    parameter int QDEPTH   = 4,
    parameter int GROUP    = 4,
    parameter int TURN_CYC = 2,
    parameter int RD_LAT   = 3
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_valid,
    output logic              wr_ready,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              rd_valid,
    output logic              rd_ready,
    input  logic [ADDR_W-1:0] rd_addr,
    input  logic [TAG_W-1:0]  rd_tag,
    output logic              mem_en,
    output logic              mem_we,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [DATA_W-1:0] mem_wdata,
    input  logic [DATA_W-1:0] mem_rdata,
    output logic              ret_valid,
    output logic [TAG_W-1:0]  ret_tag,
    output logic [DATA_W-1:0] ret_data
);
    localparam int WQ_W = ADDR_W + DATA_W;
    localparam int RQ_W = ADDR_W + TAG_W;

    logic              wq_avail, rq_avail, wq_pop, rq_pop;
    logic [WQ_W-1:0]   wq_head;
    logic [RQ_W-1:0]   rq_head;
    sched_act_t        act;
    logic [TAG_W-1:0]  cmd_tag_q;

    seg_req_fifo #(.WIDTH(WQ_W), .DEPTH(QDEPTH)) u_wq (
        .clk(clk), .rst(rst),
        .in_valid(wr_valid), .in_ready(wr_ready), .in_data({wr_addr, wr_data}),
        .out_avail(wq_avail), .out_data(wq_head), .out_pop(wq_pop)
    );

    seg_req_fifo #(.WIDTH(RQ_W), .DEPTH(QDEPTH)) u_rq (
        .clk(clk), .rst(rst),
        .in_valid(rd_valid), .in_ready(rd_ready), .in_data({rd_addr, rd_tag}),
        .out_avail(rq_avail), .out_data(rq_head), .out_pop(rq_pop)
    );

    seg_dir_ctrl #(.GROUP(GROUP), .TURN_CYC(TURN_CYC)) u_ctrl (
        .clk(clk), .rst(rst),
        .wr_avail(wq_avail), .rd_avail(rq_avail), .act(act)
    );

    assign wq_pop = act.issue && (act.dir == DIR_WR);
    assign rq_pop = act.issue && (act.dir == DIR_RD);

    always_ff @(posedge clk) begin
        if (rst) begin
            mem_en    <= 1'b0;
            mem_we    <= 1'b0;
            mem_addr  <= '0;
            mem_wdata <= '0;
            cmd_tag_q <= '0;
        end else begin
            mem_en <= act.issue;
            if (wq_pop) begin
                mem_we    <= 1'b1;
                mem_addr  <= wq_head[WQ_W-1 -: ADDR_W];
                mem_wdata <= wq_head[DATA_W-1:0];
            end else if (rq_pop) begin
                mem_we    <= 1'b0;
                mem_addr  <= rq_head[RQ_W-1 -: ADDR_W];
                cmd_tag_q <= rq_head[TAG_W-1:0];
            end
        end
    end

    seg_ret_pipe #(.TAG_W(TAG_W), .LAT(RD_LAT)) u_ret (
        .clk(clk), .rst(rst),
        .cmd_rd(mem_en && !mem_we), .cmd_tag(cmd_tag_q),
        .ret_valid(ret_valid), .ret_tag(ret_tag)
    );

    assign ret_data = mem_rdata;
endmodule

// File: rtl/seg_access_sched_chk.sv
module seg_access_sched_chk #(
    parameter int QDEPTH   = 4,
    parameter int TURN_CYC = 2
) (
    input logic clk,
    input logic rst,
    input logic wr_valid,
    input logic wr_ready,
    input logic mem_en,
    input logic mem_we,
    input logic ret_valid
);
    int unsigned pend_w, pend_r;

    always_ff @(posedge clk) begin
        if (rst) begin
            pend_w <= 0;
            pend_r <= 0;
        end else begin
            pend_w <= pend_w + ((wr_valid && wr_ready) ? 1 : 0) - ((mem_en && mem_we) ? 1 : 0);
            pend_r <= pend_r + ((mem_en && !mem_we) ? 1 : 0) - (ret_valid ? 1 : 0);
        end
    end

    AST_RESET_IDLE: assert property (@(posedge clk)
        $past(rst) |-> (!mem_en && !ret_valid && wr_ready)); // R1

    AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (rst)
        pend_w <= QDEPTH + 1); // R2

    AST_FULL_READY: assert property (@(posedge clk) disable iff (rst)
        !wr_ready |-> pend_w >= QDEPTH); // R2

    AST_RET_OWED: assert property (@(posedge clk) disable iff (rst)
        ret_valid |-> pend_r > 0); // R8

    if (TURN_CYC > 0) begin : g_gap1
        AST_TURN_GAP: assert property (@(posedge clk) disable iff (rst)
            (mem_en && $past(mem_en)) |-> (mem_we == $past(mem_we))); // R4
    end
    if (TURN_CYC > 1) begin : g_gap2
        AST_TURN_GAP2: assert property (@(posedge clk) disable iff (rst)
            (mem_en && $past(mem_en, 2)) |-> (mem_we == $past(mem_we, 2))); // R4
    end
endmodule

bind seg_access_sched seg_access_sched_chk #(.QDEPTH(QDEPTH), .TURN_CYC(TURN_CYC)) u_chk (
    .clk(clk), .rst(rst), .wr_valid(wr_valid), .wr_ready(wr_ready),
    .mem_en(mem_en), .mem_we(mem_we), .ret_valid(ret_valid)
);

// File: tb/seg_access_sched_test.sv
module seg_access_sched_test;
    localparam int CLK_PERIOD = 10;
    localparam int ADDR_W = 16, DATA_W = 576, TAG_W = 6;
    localparam int QDEPTH = 4, GROUP = 4, TURN_CYC = 2, RD_LAT = 3;

    logic clk = 0, rst = 1;
    logic wr_valid = 0, rd_valid = 0;
    logic wr_ready, rd_ready, mem_en, mem_we, ret_valid;
    logic [ADDR_W-1:0] wr_addr = '0, rd_addr = '0, mem_addr;
    logic [DATA_W-1:0] wr_data = '0, mem_wdata, ret_data;
    logic [DATA_W-1:0] mem_rdata = '0;
    logic [TAG_W-1:0]  rd_tag = '0, ret_tag;

    always #(CLK_PERIOD/2) clk = ~clk;

    seg_access_sched #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .TAG_W(TAG_W), .QDEPTH(QDEPTH),
        .GROUP(GROUP), .TURN_CYC(TURN_CYC), .RD_LAT(RD_LAT)) uut (.*);

    int vectors = 0, miscompares = 0, cyc = 0;

    task automatic chk(input bit ok, input string req, input string what,
                       input logic [DATA_W-1:0] act, input logic [DATA_W-1:0] exp);
        vectors++;
        if (!ok) begin
            miscompares++;
            $display("FAIL %s %s at cycle %0d: actual=%0h expected=%0h", req, what, cyc, act, exp);
        end
    endtask

    // reference model state
    typedef struct { logic [ADDR_W-1:0] a; logic [DATA_W-1:0] d; } wreq_t;
    typedef struct { logic [ADDR_W-1:0] a; logic [TAG_W-1:0] t; } rreq_t;
    typedef struct { int due; logic [TAG_W-1:0] t; logic [DATA_W-1:0] d; } ret_t;
    wreq_t wq[$];
    rreq_t rq[$];
    ret_t  retq[$];
    logic [DATA_W-1:0] refmem [logic [ADDR_W-1:0]];
    logic [DATA_W-1:0] tbmem  [logic [ADDR_W-1:0]];
    bit m_dir = 0;
    int m_cnt = 0, m_turn = 0;
    bit e_en = 0, e_we = 0;
    logic [ADDR_W-1:0] e_addr = '0;
    logic [DATA_W-1:0] e_wdata = '0;
    bit w_acc_last = 0, r_acc_last = 0;

    // stimulus control
    int pw = 0, pr = 0;
    bit inj_w = 0, inj_r = 0;
    int inj_cyc = 0;
    logic [TAG_W-1:0] next_tag = '0;

    // memory port sampling and model
    bit s_en = 0, s_we = 0;
    logic [ADDR_W-1:0] s_addr = '0;
    logic [DATA_W-1:0] s_wdata = '0;
    logic [DATA_W-1:0] line [RD_LAT];
    bit win_on = 0;
    int nw = 0, nr = 0;

    function automatic logic [DATA_W-1:0] rand_seg();
        logic [DATA_W-1:0] v;
        for (int i = 0; i < DATA_W/32; i++) v[i*32 +: 32] = $urandom;
        return v;
    endfunction

    always @(posedge clk) begin
        if (rst) begin
            wq.delete(); rq.delete(); retq.delete();
            m_dir = 0; m_cnt = 0; m_turn = 0; e_en = 0; e_we = 0;
            w_acc_last = 0; r_acc_last = 0;
        end else begin
            bit wacc, racc, cur, oth, iss, idir;
            wreq_t w;
            rreq_t r;
            wacc = wr_valid && (wq.size() < QDEPTH);
            racc = rd_valid && (rq.size() < QDEPTH);
            cur  = m_dir ? (rq.size() > 0) : (wq.size() > 0);
            oth  = m_dir ? (wq.size() > 0) : (rq.size() > 0);
            iss = 0; idir = m_dir;
            if (m_turn > 0) m_turn--;
            else if (cur && m_cnt < GROUP) begin iss = 1; m_cnt++; end
            else if (oth) begin
                m_dir = !m_dir;
                if (TURN_CYC == 0) begin iss = 1; idir = m_dir; m_cnt = 1; end
                else begin m_cnt = 0; m_turn = TURN_CYC - 1; end
            end
            else if (cur) begin iss = 1; m_cnt = 1; end
            e_en = iss;
            if (iss) begin
                e_we = !idir;
                if (!idir) begin
                    w = wq.pop_front();
                    e_addr = w.a; e_wdata = w.d;
                    refmem[w.a] = w.d;
                end else begin
                    r = rq.pop_front();
                    e_addr = r.a;
                    retq.push_back('{cyc + 1 + RD_LAT, r.t,
                                     refmem.exists(r.a) ? refmem[r.a] : '0});
                end
            end
            if (wacc) wq.push_back('{wr_addr, wr_data});
            if (racc) rq.push_back('{rd_addr, rd_tag});
            w_acc_last = wacc; r_acc_last = racc;
        end
        // memory array with fixed read latency
        for (int i = RD_LAT - 1; i > 0; i--) line[i] = line[i-1];
        line[0] = (s_en && !s_we) ? (tbmem.exists(s_addr) ? tbmem[s_addr] : '0) : '0;
        if (s_en && s_we) tbmem[s_addr] = s_wdata;
        mem_rdata = line[RD_LAT-1];
        cyc++;
    end

    // compare against the model every cycle, and drive stimulus
    always @(negedge clk) begin
        s_en = mem_en; s_we = mem_we; s_addr = mem_addr; s_wdata = mem_wdata;
        if (!rst && cyc > 0) begin
            bit er;
            chk(mem_en == e_en, "R3,R4,R5,R6", "mem_en", mem_en, e_en);
            if (e_en && mem_en) begin
                chk(mem_we == e_we, "R3,R7", "mem_we", mem_we, e_we);
                chk(mem_addr == e_addr, "R7", "mem_addr", mem_addr, e_addr);
                if (e_we) chk(mem_wdata == e_wdata, "R7", "mem_wdata", mem_wdata, e_wdata);
            end
            chk(wr_ready == (wq.size() < QDEPTH), "R2", "wr_ready", wr_ready, wq.size() < QDEPTH);
            chk(rd_ready == (rq.size() < QDEPTH), "R2", "rd_ready", rd_ready, rq.size() < QDEPTH);
            er = (retq.size() > 0) && (retq[0].due == cyc);
            chk(ret_valid == er, "R8", "ret_valid", ret_valid, er);
            if (er) begin
                ret_t x;
                x = retq.pop_front();
                chk(ret_tag == x.t, "R8", "ret_tag", ret_tag, x.t);
                chk(ret_data == x.d, "R8", "ret_data", ret_data, x.d);
            end
            if (win_on && mem_en) begin
                if (mem_we) nw++; else nr++;
            end
        end
        if (rst) begin
            wr_valid = 0; rd_valid = 0;
        end else begin
            if (!wr_valid || w_acc_last) begin
                if (inj_w || (pw > 0 && $urandom_range(99) < pw)) begin
                    if (inj_w) inj_cyc = cyc;
                    inj_w = 0;
                    wr_valid = 1; wr_addr = ADDR_W'($urandom_range(15)); wr_data = rand_seg();
                end else wr_valid = 0;
            end
            if (!rd_valid || r_acc_last) begin
                if (inj_r || (pr > 0 && $urandom_range(99) < pr)) begin
                    if (inj_r) inj_cyc = cyc;
                    inj_r = 0;
                    rd_valid = 1; rd_addr = ADDR_W'($urandom_range(15)); rd_tag = next_tag;
                    next_tag = next_tag + 1'b1;
                end else rd_valid = 0;
            end
        end
    end

    task automatic run(input int w, input int r, input int n);
        pw = w; pr = r;
        repeat (n) @(posedge clk);
    endtask

    task automatic expect_single(input bit is_wr, input int delay, input string req);
        int seen;
        seen = -1;
        @(posedge clk);
        if (is_wr) inj_w = 1; else inj_r = 1;
        repeat (20) begin
            @(negedge clk);
            if (mem_en && (mem_we == is_wr) && seen < 0) seen = cyc;
        end
        chk(seen == inj_cyc + delay, req, "single-request latency",
            DATA_W'(seen - inj_cyc), DATA_W'(delay));
    endtask

    task automatic summary();
        $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    endtask

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk); rst = 0;
        @(negedge clk);
        // R1: reset state at the ports
        chk(!mem_en, "R1", "mem_en after reset", mem_en, 0);
        chk(wr_ready && rd_ready, "R1", "ready after reset", {wr_ready, rd_ready}, 2'b11);
        chk(!ret_valid, "R1", "ret_valid after reset", ret_valid, 0);
        // R1: direction starts at write, no gap
        expect_single(1, 2, "R1");
        run(0, 0, 20);
        // R3/R9: saturated load
        run(100, 100, 60);
        nw = 0; nr = 0; win_on = 1;
        run(100, 100, 120);
        win_on = 0;
        chk(nw == 40, "R9", "writes per 120 cycles", nw, 40);
        chk(nr == 40, "R9", "reads per 120 cycles", nr, 40);
        run(100, 100, 60);
        run(0, 0, 40);
        // R6: write-only stream, groups continue without gaps
        run(100, 0, 40);
        nw = 0; nr = 0; win_on = 1;
        run(100, 0, 40);
        win_on = 0;
        chk(nw == 40, "R6", "back-to-back writes", nw, 40);
        run(0, 0, 30);
        run(0, 100, 40);
        nw = 0; nr = 0; win_on = 1;
        run(0, 100, 40);
        win_on = 0;
        chk(nr == 40, "R6", "back-to-back reads", nr, 40);
        run(0, 0, 30);
        // R6: idle scheduler holds read direction
        expect_single(0, 2, "R6");
        run(0, 0, 20);
        // R5/R4: lone write forces an early switch with turnaround
        expect_single(1, 2 + TURN_CYC, "R5");
        run(0, 0, 20);
        // R5: lone read forces a switch back
        expect_single(0, 2 + TURN_CYC, "R5");
        run(0, 0, 20);
        // mixed traffic
        run(40, 40, 600);
        run(80, 20, 500);
        run(20, 80, 500);
        run(60, 60, 500);
        run(0, 0, 40);
        summary();
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        vectors++; miscompares++;
        $display("FAIL watchdog expired at cycle %0d: actual=running expected=finished", cyc);
        summary();
        $finish;
    end
endmodule